// File: doc/BRIEF.md
# Probe-then-Lock Save-Area Window Control Register

This block holds a single byte-wide control register. The register decides whether a small, fixed, low-address RAM window is kept for code that runs in system management mode (SMM). Firmware drives it through a byte-wide configuration write port and reads it back on a read port. An SMM-mode input marks the access that is currently in flight as coming from SMM or not.

Each write moves the register one step along a fixed path. Out of reset it ignores ordinary writes. A probe write answers with a fixed acknowledge value and opens the lock bit alone to writes. Setting that bit then freezes the register until the next reset. While the register is locked, an access from outside SMM is steered to a hole that returns all ones and drops writes. An access from SMM is steered to the RAM window. A parameter removes the whole feature, which leaves a plain read/write byte that never enables either path. Decoding the window address and storing its contents belong to other logic.

Top module: `smsave_lock_reg`

## Requirements
- R1: After reset, cfg_rdata reads 0x00 and both hole_en and win_en are 0, whatever the level of smm_mode.
- R2: Before a probe, any write whose data is not the probe code 0xFF is discarded: on the cycle after it, cfg_rdata still reads 0x00 and the window stays disabled. A lone 0x02 write counts as such a write.
- R3: A write of the probe code 0xFF before any probe makes cfg_rdata read the acknowledge code 0x01 on the following cycle.
- R4: Once the register has been probed, a write with bit 1 clear leaves cfg_rdata at 0x01 and does not enable the window.
- R5: Once the register has been probed, a write with bit 1 (lock, value 0x02) set makes cfg_rdata read exactly 0x02 on the following cycle and locks the register.
- R6: While the register is locked, every write is ignored, including 0x00 and 0xFF, and cfg_rdata stays 0x02.
- R7: While the register is locked, hole_en equals NOT smm_mode and win_en equals smm_mode, both combinationally. While it is not locked, both are 0. The two are never 1 together.
- R8: Only reset clears the lock. After reset the probe step must be repeated before the lock can be set again.
- R9: With FEATURE_EN = 0 the register is a plain byte: each write is stored as written and read back on the next cycle, and hole_en and win_en stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the register |
| cfg_wdata | input | DATA_W | Write data |
| cfg_rdata | output | DATA_W | Current register value |
| smm_mode | input | 1 | The access in flight comes from SMM |
| hole_en | output | 1 | Steer the non-SMM access to the all-ones hole |
| win_en | output | 1 | Steer the SMM access to the RAM window |

## Verification
The lock write and the routing of the current access can fall in the same cycle. The bench provokes this by driving the lock write together with a chosen smm_mode level, then flipping smm_mode with no write in the cycle after. It checks that the routing outputs follow the state the register held before the clock edge, and change only on the edge that commits the lock. Within a single locked state, hole_en and win_en must swap at once each time smm_mode toggles.

// File: rtl/smsave_pkg.sv
package smsave_pkg;
   // Register life cycle; SV_OFF marks the feature-less plain-byte variant
   typedef enum logic [1:0] {
      SV_OFF    = 2'd0,
      SV_OPEN   = 2'd1,
      SV_ACKED  = 2'd2,
      SV_LOCKED = 2'd3
   } sv_state_e;
endpackage

// File: rtl/smsave_seq.sv
module smsave_seq
   import smsave_pkg::*;
#(
   parameter int          DATA_W     = 8,
   parameter logic [DATA_W-1:0] PROBE_CODE = 8'hFF,
   parameter logic [DATA_W-1:0] LOCK_MASK  = 8'h02
) (
   input  sv_state_e         st_cur,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output sv_state_e         st_nxt
);
   logic is_probe;
   logic has_lock;

   assign is_probe = (wdata == PROBE_CODE);
   assign has_lock = ((wdata & LOCK_MASK) != '0);

   always_comb begin
      st_nxt = st_cur;
      unique case (st_cur)
         SV_OPEN:   if (wr && is_probe) st_nxt = SV_ACKED;
         SV_ACKED:  if (wr && has_lock) st_nxt = SV_LOCKED;
         SV_LOCKED: st_nxt = SV_LOCKED;
         default:   st_nxt = st_cur;
      endcase
   end
endmodule

// File: rtl/smsave_readback.sv
module smsave_readback
   import smsave_pkg::*;
#(
   parameter int          DATA_W    = 8,
   parameter logic [DATA_W-1:0] ACK_CODE  = 8'h01,
   parameter logic [DATA_W-1:0] LOCK_MASK = 8'h02
) (
   input  sv_state_e         st,
   input  logic [DATA_W-1:0] plain_val,
   output logic [DATA_W-1:0] rdata
);
   always_comb begin
      unique case (st)
         SV_OFF:    rdata = plain_val;
         SV_OPEN:   rdata = '0;
         SV_ACKED:  rdata = ACK_CODE;
         SV_LOCKED: rdata = LOCK_MASK;
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/smsave_route.sv
module smsave_route
   import smsave_pkg::*;
(
   input  sv_state_e st,
   input  logic      smm,
   output logic      hole,
   output logic      win
);
   logic armed;

   assign armed = (st == SV_LOCKED);
   assign hole  = armed & ~smm;
   assign win   = armed &  smm;
endmodule

// File: rtl/smsave_lock_reg.sv
module smsave_lock_reg
   import smsave_pkg::*;
#(
   parameter int          DATA_W     = 8,
   parameter bit          FEATURE_EN = 1'b1,
   parameter logic [DATA_W-1:0] PROBE_CODE = 8'hFF,
   parameter logic [DATA_W-1:0] ACK_CODE   = 8'h01,
   parameter logic [DATA_W-1:0] LOCK_MASK  = 8'h02
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic              smm_mode,
   output logic              hole_en,
   output logic              win_en
);
   localparam int LOCK_BITS = $countones(LOCK_MASK);

   // Elaboration-time parameter checks
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("smsave_lock_reg: DATA_W must be at least 2");
      end
      if (LOCK_BITS != 1) begin : g_bad_lock
         $error("smsave_lock_reg: LOCK_MASK must have exactly one bit set");
      end
      if ((ACK_CODE & LOCK_MASK) != '0) begin : g_bad_ack
         $error("smsave_lock_reg: ACK_CODE must not contain the lock bit");
      end
      if (PROBE_CODE == '0) begin : g_bad_probe
         $error("smsave_lock_reg: PROBE_CODE must be non-zero");
      end
   endgenerate

   sv_state_e         st_q;
   logic [DATA_W-1:0] plain_q;

   generate
      if (FEATURE_EN) begin : g_lock
         sv_state_e st_d;

         smsave_seq #(
            .DATA_W     (DATA_W),
            .PROBE_CODE (PROBE_CODE),
            .LOCK_MASK  (LOCK_MASK)
         ) u_seq (
            .st_cur (st_q),
            .wr     (cfg_wr),
            .wdata  (cfg_wdata),
            .st_nxt (st_d)
         );

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= SV_OPEN;
            else        st_q <= st_d;
         end

         assign plain_q = '0;
      end else begin : g_plain
         assign st_q = SV_OFF;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      plain_q <= '0;
            else if (cfg_wr) plain_q <= cfg_wdata;
         end
      end
   endgenerate

   smsave_readback #(
      .DATA_W    (DATA_W),
      .ACK_CODE  (ACK_CODE),
      .LOCK_MASK (LOCK_MASK)
   ) u_rb (
      .st        (st_q),
      .plain_val (plain_q),
      .rdata     (cfg_rdata)
   );

   smsave_route u_route (
      .st   (st_q),
      .smm  (smm_mode),
      .hole (hole_en),
      .win  (win_en)
   );
endmodule

// File: rtl/smsave_lock_chk.sv
module smsave_lock_chk
   import smsave_pkg::*;
#(
   parameter int          DATA_W     = 8,
   parameter bit          FEATURE_EN = 1'b1,
   parameter logic [DATA_W-1:0] PROBE_CODE = 8'hFF,
   parameter logic [DATA_W-1:0] ACK_CODE   = 8'h01,
   parameter logic [DATA_W-1:0] LOCK_MASK  = 8'h02
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic [DATA_W-1:0] cfg_rdata,
   input logic              smm_mode,
   input logic              hole_en,
   input logic              win_en,
   input sv_state_e         st_q
);
   // R7
   hole_win_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hole_en && win_en));

   // R7
   hole_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hole_en |-> !smm_mode);

   // R7
   win_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_en |-> smm_mode);

   // R2
   open_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SV_OPEN && cfg_wr && cfg_wdata != PROBE_CODE) |=> (cfg_rdata == '0));

   // R3
   probe_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SV_OPEN && cfg_wr && cfg_wdata == PROBE_CODE) |=> (cfg_rdata == ACK_CODE));

   // R5
   locked_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hole_en || win_en) |-> (cfg_rdata == LOCK_MASK));

   // R6
   locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SV_LOCKED) |=> $stable(cfg_rdata));

   // R8
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SV_LOCKED) |=> (st_q == SV_LOCKED));

   // R9
   plain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SV_OFF) |-> (!hole_en && !win_en));
endmodule

bind smsave_lock_reg smsave_lock_chk #(
   .DATA_W     (DATA_W),
   .FEATURE_EN (FEATURE_EN),
   .PROBE_CODE (PROBE_CODE),
   .ACK_CODE   (ACK_CODE),
   .LOCK_MASK  (LOCK_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_wr    (cfg_wr),
   .cfg_wdata (cfg_wdata),
   .cfg_rdata (cfg_rdata),
   .smm_mode  (smm_mode),
   .hole_en   (hole_en),
   .win_en    (win_en),
   .st_q      (st_q)
);

// File: tb/smsave_lock_reg_bench.sv
module smsave_lock_reg_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic       smm_mode = 1'b0;
   logic [7:0] rd_main, rd_plain;
   logic       hole_main, win_main, hole_plain, win_plain;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   smsave_lock_reg u_smsave_lock_reg (
      .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_wdata (cfg_wdata),
      .cfg_rdata (rd_main), .smm_mode (smm_mode),
      .hole_en (hole_main), .win_en (win_main)
   );

   smsave_lock_reg #(.FEATURE_EN (1'b0)) u_smsave_lock_reg_plain (
      .clk (clk), .rst_n (rst_n), .cfg_wr (cfg_wr), .cfg_wdata (cfg_wdata),
      .cfg_rdata (rd_plain), .smm_mode (smm_mode),
      .hole_en (hole_plain), .win_en (win_plain)
   );

   typedef struct {
      logic [7:0] rd;
      logic       hole;
      logic       win;
      logic [7:0] rd_p;
      string      tag;
   } exp_t;

   exp_t sb_q[$];

   // Reference model, written from the requirements
   int         m_st = 0;      // 0 unprobed, 1 probed, 2 locked
   logic [7:0] m_plain = 8'h00;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic wr, input logic [7:0] d, input logic smm, input string tag);
      exp_t e;
      @(negedge clk);
      cfg_wr    = wr;
      cfg_wdata = d;
      smm_mode  = smm;
      if (wr) begin
         case (m_st)
            0: if (d == 8'hFF) m_st = 1;
            1: if (d[1]) m_st = 2;
            default: m_st = 2;
         endcase
         m_plain = d;
      end
      e.rd   = (m_st == 0) ? 8'h00 : (m_st == 1) ? 8'h01 : 8'h02;
      e.hole = (m_st == 2) && !smm;
      e.win  = (m_st == 2) && smm;
      e.rd_p = m_plain;
      e.tag  = tag;
      sb_q.push_back(e);
   endtask

   // Monitor: sample 5 ns after the edge that commits each driven cycle
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check({e.tag, " rdata"}, rd_main, e.rd);
            check({e.tag, " hole"}, hole_main, e.hole);
            check({e.tag, " win"}, win_main, e.win);
            check({e.tag, " R9 plain rdata"}, rd_plain, e.rd_p);
            check({e.tag, " R9 plain routes"}, {hole_plain, win_plain}, 2'b00);
         end
      end
   end

   task automatic do_reset(input string tag);
      @(negedge clk);
      cfg_wr = 1'b0;
      rst_n  = 1'b0;
      m_st = 0;
      m_plain = 8'h00;
      smm_mode = 1'b1;
      #2;
      check({tag, " rdata"}, rd_main, 8'h00);
      check({tag, " routes smm=1"}, {hole_main, win_main}, 2'b00);
      smm_mode = 1'b0;
      #2;
      check({tag, " routes smm=0"}, {hole_main, win_main}, 2'b00);
      check({tag, " R9 plain rdata"}, rd_plain, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(20 * 50000);
      n_fail++;
      $display("FAIL watchdog expired");
      done = 1'b1;
   end

   initial begin
      repeat (3) @(posedge clk);
      do_reset("R1 reset");
      drive(1'b0, 8'h00, 1'b0, "R1 idle");
      drive(1'b1, 8'h02, 1'b0, "R2 lock before probe");
      drive(1'b1, 8'h5A, 1'b1, "R2 junk before probe");
      drive(1'b1, 8'hFF, 1'b0, "R3 probe");
      drive(1'b1, 8'h01, 1'b0, "R4 ack rewrite");
      drive(1'b1, 8'hFD, 1'b1, "R4 bit1 clear");
      drive(1'b0, 8'h00, 1'b1, "R7 unlocked smm");
      drive(1'b1, 8'h02, 1'b0, "R5 lock with non-smm");
      drive(1'b0, 8'h00, 1'b1, "R7 locked smm");
      drive(1'b0, 8'h00, 1'b0, "R7 locked non-smm");
      drive(1'b1, 8'h00, 1'b0, "R6 write zero");
      drive(1'b1, 8'hFF, 1'b1, "R6 write probe");
      drive(1'b0, 8'h00, 1'b0, "R6 idle");
      repeat (2) @(posedge clk);
      do_reset("R8 reset clears lock");
      drive(1'b1, 8'h02, 1'b1, "R8 lock without re-probe");
      drive(1'b1, 8'hFF, 1'b1, "R8 re-probe");
      drive(1'b1, 8'hFF, 1'b1, "R5 lock via probe code");
      drive(1'b0, 8'h00, 1'b0, "R7 toggle to non-smm");
      repeat (3) @(posedge clk);
      done = 1'b1;
   end

   initial begin
      wait (done);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule